// File: doc/BRIEF.md
# Register-Hazard Search Queue

This block is a short in-order queue placed between the decode and execute stages of a two-stage pipeline. Decode pushes one decoded operation record per cycle. Execute reads the oldest record at the head and then retires it. When a taken conditional branch redirects the program counter, execute flushes the whole queue.

The queue also answers one combinational question for decode: does any record still in flight write a given register? Decode asks this for each source register of the operation it holds. It stalls while any of them is reported busy, which avoids read-after-write hazards.

Within a cycle the operations take effect in a fixed order: head read, then retire or flush, then search, then push. A record retiring in the same cycle therefore never reports busy. A record being pushed in the same cycle is not yet visible to the search.

Top module: `sbq_scoreboard_fifo`

## Requirements
- R1: After reset the queue is empty (`empty`=1, `full`=0) and `findHit` is 0.
- R2: Records leave in the order they entered. While the queue is not empty, the head ports show the oldest record unchanged, combinationally. The kind encoding is add=0, branch-if-zero=1, load=2, store=3.
- R3: `full` is 1 when DEPTH records are held. A push requested while `full` is 1 and `clear` is 0 is ignored.
- R4: A retire request while `empty` is 1 is ignored.
- R5: `findHit` is 1 when some held record of kind add (0) or load (2) has its destination field equal to `findReg`.
- R6: Records of kind branch-if-zero (1) or store (3) never cause a hit, whatever their destination field holds.
- R7: The head record being retired in the current cycle is excluded from the search. While `clear` is 1, `findHit` is 0.
- R8: A record being pushed in the current cycle is not searched.
- R9: `clear` discards every held record. When `clear` and a push occur together, the queue afterwards holds only the pushed record, even if it was full.
- R10: Order and search stay correct across pointer wrap-around when pushes and retires happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enqValid | input | 1 | Push request |
| enqKind | input | 2 | Kind of pushed record |
| enqDst | input | 5 | Destination register of pushed record |
| enqValA | input | 32 | First value (operand 1, condition, or store data) |
| enqValB | input | 32 | Second value (operand 2, target, or address) |
| full | output | 1 | Queue holds DEPTH records |
| deqReq | input | 1 | Retire the head record |
| empty | output | 1 | Queue holds no record |
| headKind | output | 2 | Kind of head record |
| headDst | output | 5 | Destination of head record |
| headValA | output | 32 | First value of head record |
| headValB | output | 32 | Second value of head record |
| clear | input | 1 | Flush all records |
| findReg | input | 5 | Register name to search |
| findHit | output | 1 | Some held record writes findReg |

## Verification
Some properties are checked by assertions on every cycle. These are: no hit during a flush or on an empty queue, the effect of a flush with and without a push, a push being ignored while full, a retire being ignored while empty, and a single push into an empty queue appearing at the head.

Other behaviour depends on the contents of the queue, and only the bench's scenarios and its reference queue can show it. This covers the kind-dependent match rule, exclusion of the retiring record, invisibility of the pushed record, ordering across wrap-around, and the mixed random traffic.

// File: rtl/sbq_pkg.sv
package sbq_pkg;
  localparam int REG_W  = 5;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    OP_ADD   = 2'd0,
    OP_BRZ   = 2'd1,
    OP_LOAD  = 2'd2,
    OP_STORE = 2'd3
  } opKind_e;

  typedef struct packed {
    opKind_e             kind;
    logic [REG_W-1:0]    dst;
    logic [DATA_W-1:0]   valA;
    logic [DATA_W-1:0]   valB;
  } sbqEntry_t;

  typedef struct packed {
    logic enqWrite;
    logic deqRelease;
    logic flushAll;
  } sbqStrobe_t;

  // only register-producing kinds take part in the search
  function automatic logic writesReg(sbqEntry_t e, logic [REG_W-1:0] r);
    return ((e.kind == OP_ADD) || (e.kind == OP_LOAD)) && (e.dst == r);
  endfunction
endpackage

// File: rtl/sbq_ctrl.sv
module sbq_ctrl #(
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       enqValid,
  input  logic                       deqReq,
  input  logic                       clear,
  output sbq_pkg::sbqStrobe_t        strobe,
  output logic [$clog2(DEPTH)-1:0]   headIdx,
  output logic [$clog2(DEPTH)-1:0]   enqIdx,
  output logic                       isFull,
  output logic                       isEmpty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] headPtr, tailPtr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  assign isFull  = (count == CNT_W'(DEPTH));
  assign isEmpty = (count == '0);

  always_comb begin
    strobe.flushAll   = clear;
    strobe.deqRelease = deqReq && !isEmpty && !clear;
    strobe.enqWrite   = enqValid && (!isFull || clear);
  end

  assign headIdx = headPtr;
  assign enqIdx  = clear ? '0 : tailPtr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      headPtr <= '0;
      tailPtr <= '0;
      count   <= '0;
    end else if (strobe.flushAll) begin
      headPtr <= '0;
      tailPtr <= strobe.enqWrite ? PTR_W'(1) : '0;
      count   <= strobe.enqWrite ? CNT_W'(1) : '0;
    end else begin
      if (strobe.deqRelease) headPtr <= bump(headPtr);
      if (strobe.enqWrite)   tailPtr <= bump(tailPtr);
      count <= count + CNT_W'(strobe.enqWrite) - CNT_W'(strobe.deqRelease);
    end
  end
endmodule

// File: rtl/sbq_datapath.sv
module sbq_datapath #(
  parameter int DEPTH = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  sbq_pkg::sbqStrobe_t               strobe,
  input  logic [$clog2(DEPTH)-1:0]          headIdx,
  input  logic [$clog2(DEPTH)-1:0]          enqIdx,
  input  sbq_pkg::sbqEntry_t                enqEntry,
  input  logic [sbq_pkg::REG_W-1:0]         findReg,
  output sbq_pkg::sbqEntry_t                headEntry,
  output logic                              findHit
);
  import sbq_pkg::*;
  localparam int PTR_W = $clog2(DEPTH);

  sbqEntry_t        slotView [DEPTH];
  logic [DEPTH-1:0] hitVec;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    localparam logic [PTR_W-1:0] IDX = PTR_W'(g);
    sbqEntry_t slotReg;
    logic      slotLive;
    logic      writeHere;
    logic      leaveHere;

    assign writeHere = strobe.enqWrite && (enqIdx == IDX);
    assign leaveHere = strobe.deqRelease && (headIdx == IDX);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               slotLive <= 1'b0;
      else if (strobe.flushAll) slotLive <= writeHere;
      else if (writeHere)       slotLive <= 1'b1;
      else if (leaveHere)       slotLive <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (writeHere) slotReg <= enqEntry;
    end

    assign slotView[g] = slotReg;
    // search sees the queue after retire, before push
    assign hitVec[g] = slotLive && !leaveHere && writesReg(slotReg, findReg);
  end

  assign headEntry = slotView[headIdx];
  assign findHit   = (|hitVec) && !strobe.flushAll;
endmodule

// File: rtl/sbq_scoreboard_fifo.sv
module sbq_scoreboard_fifo #(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enqValid,
  input  logic [1:0]  enqKind,
  input  logic [4:0]  enqDst,
  input  logic [31:0] enqValA,
  input  logic [31:0] enqValB,
  output logic        full,
  input  logic        deqReq,
  output logic        empty,
  output logic [1:0]  headKind,
  output logic [4:0]  headDst,
  output logic [31:0] headValA,
  output logic [31:0] headValB,
  input  logic        clear,
  input  logic [4:0]  findReg,
  output logic        findHit
);
  import sbq_pkg::*;
  localparam int PTR_W = $clog2(DEPTH);

  sbqStrobe_t       strobe;
  logic [PTR_W-1:0] headIdx, enqIdx;
  sbqEntry_t        enqEntry, headEntry;

  always_comb begin
    enqEntry.kind = opKind_e'(enqKind);
    enqEntry.dst  = enqDst;
    enqEntry.valA = enqValA;
    enqEntry.valB = enqValB;
  end

  sbq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enqValid(enqValid), .deqReq(deqReq),
    .clear(clear), .strobe(strobe), .headIdx(headIdx), .enqIdx(enqIdx),
    .isFull(full), .isEmpty(empty)
  );

  sbq_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .headIdx(headIdx),
    .enqIdx(enqIdx), .enqEntry(enqEntry), .findReg(findReg),
    .headEntry(headEntry), .findHit(findHit)
  );

  assign headKind = headEntry.kind;
  assign headDst  = headEntry.dst;
  assign headValA = headEntry.valA;
  assign headValB = headEntry.valB;
endmodule

// File: rtl/sbq_checker.sv
module sbq_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        enqValid,
  input logic [1:0]  enqKind,
  input logic [4:0]  enqDst,
  input logic [31:0] enqValA,
  input logic [31:0] enqValB,
  input logic        full,
  input logic        deqReq,
  input logic        empty,
  input logic [1:0]  headKind,
  input logic [4:0]  headDst,
  input logic [31:0] headValA,
  input logic [31:0] headValB,
  input logic        clear,
  input logic [4:0]  findReg,
  input logic        findHit
);
  // R2
  first_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty && enqValid && !clear |=> !empty && headValA == $past(enqValA) && headDst == $past(enqDst));
  // R3
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && enqValid && !deqReq && !clear |=> full && $stable(headValB));
  // R4
  empty_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty && deqReq && !enqValid && !clear |=> empty);
  // R7
  flush_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |-> !findHit);
  // R8
  empty_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !findHit);
  // R9
  flush_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear && !enqValid |=> empty);
  // R9
  flush_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear && enqValid |=> !empty && !full && headKind == $past(enqKind) && headDst == $past(enqDst));
endmodule

bind sbq_scoreboard_fifo sbq_checker u_chk (.*);

// File: tb/sbq_scoreboard_fifo_bench.sv
`timescale 1ns/1ps
module sbq_scoreboard_fifo_bench;
  import sbq_pkg::*;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enqValid = 0, deqReq = 0, clear = 0;
  logic [1:0] enqKind = 0;
  logic [4:0] enqDst = 0, findReg = 0, headDst;
  logic [31:0] enqValA = 0, enqValB = 0, headValA, headValB;
  logic [1:0] headKind;
  logic full, empty, findHit;

  int total = 0, bad = 0;
  bit finished = 0;
  sbqEntry_t model[$];

  always #2.5 clk = ~clk;

  sbq_scoreboard_fifo #(.DEPTH(DEPTH)) u_sbq_scoreboard_fifo (.*);

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit e, logic [1:0] k, logic [4:0] d, logic [31:0] a,
                      logic [31:0] b, bit dq, bit cl, logic [4:0] fr);
    bit expFind;
    bit wasFull;
    sbqEntry_t ne;
    @(negedge clk);
    enqValid = e; enqKind = k; enqDst = d; enqValA = a; enqValB = b;
    deqReq = dq; clear = cl; findReg = fr;
    #1;
    expFind = 0;
    if (!cl) begin
      for (int j = 0; j < model.size(); j++) begin
        if (j == 0 && dq) continue;
        if ((model[j].kind == OP_ADD || model[j].kind == OP_LOAD) && model[j].dst == fr)
          expFind = 1;
      end
    end
    check(tag, "empty", 32'(empty), 32'(model.size() == 0));
    check(tag, "full", 32'(full), 32'(model.size() == DEPTH));
    check(tag, "findHit", 32'(findHit), 32'(expFind));
    if (model.size() > 0) begin
      check(tag, "headKind", 32'(headKind), 32'(model[0].kind));
      check(tag, "headDst", 32'(headDst), 32'(model[0].dst));
      check(tag, "headValA", headValA, model[0].valA);
      check(tag, "headValB", headValB, model[0].valB);
    end
    wasFull = (model.size() == DEPTH);
    if (cl) model.delete();
    else if (dq && model.size() > 0) void'(model.pop_front());
    if (e && (!wasFull || cl)) begin
      ne.kind = opKind_e'(k); ne.dst = d; ne.valA = a; ne.valB = b;
      model.push_back(ne);
    end
  endtask

  task automatic idle(string tag, logic [4:0] fr);
    step(tag, 0, 0, 0, 0, 0, 0, 0, fr);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    idle("R1", 5'd0);
    // R5: add and load produce hits
    step("R5", 1, 2'd0, 5'd3, 32'h11, 32'h22, 0, 0, 5'd3);
    idle("R5", 5'd3);
    idle("R5", 5'd4);
    step("R5", 1, 2'd2, 5'd9, 32'h33, 32'h44, 0, 0, 5'd9);
    idle("R5", 5'd9);
    // R6: branch and store never hit
    step("R9", 0, 0, 0, 0, 0, 0, 1, 5'd3);
    step("R6", 1, 2'd3, 5'd7, 32'h55, 32'h66, 0, 0, 5'd7);
    step("R6", 1, 2'd1, 5'd8, 32'h0, 32'h77, 0, 0, 5'd7);
    idle("R6", 5'd7);
    idle("R6", 5'd8);
    // R3: fill, overflow push ignored
    step("R3", 1, 2'd0, 5'd1, 32'ha1, 32'hb1, 0, 0, 5'd1);
    step("R3", 1, 2'd2, 5'd2, 32'ha2, 32'hb2, 0, 0, 5'd2);
    step("R3", 1, 2'd0, 5'd12, 32'ha3, 32'hb3, 0, 0, 5'd12);
    idle("R3", 5'd12);
    // R2: drain in order
    for (int i = 0; i < 4; i++) step("R2", 0, 0, 0, 0, 0, 1, 0, 5'd2);
    // R4: retire on empty ignored
    step("R4", 0, 0, 0, 0, 0, 1, 0, 5'd0);
    idle("R4", 5'd0);
    // R8: pushed record not yet visible
    step("R8", 1, 2'd0, 5'd5, 32'h1, 32'h2, 0, 0, 5'd5);
    idle("R8", 5'd5);
    // R7: retiring head excluded
    step("R7", 0, 0, 0, 0, 0, 1, 0, 5'd5);
    idle("R7", 5'd5);
    step("R7", 1, 2'd0, 5'd6, 32'h3, 32'h4, 0, 0, 5'd6);
    step("R7", 1, 2'd0, 5'd6, 32'h5, 32'h6, 1, 0, 5'd6);
    step("R7", 0, 0, 0, 0, 0, 0, 1, 5'd6);
    // R9: flush of a full queue with push
    for (int i = 0; i < 4; i++) step("R9", 1, 2'd2, 5'(i), 32'(i), 32'(i + 8), 0, 0, 5'd0);
    step("R9", 1, 2'd0, 5'd20, 32'hcc, 32'hdd, 0, 1, 5'd0);
    idle("R9", 5'd20);
    step("R9", 0, 0, 0, 0, 0, 1, 0, 5'd20);
    idle("R9", 5'd20);
    // R10: streaming across wrap
    step("R10", 1, 2'd0, 5'd1, 32'h100, 32'h0, 0, 0, 5'd1);
    step("R10", 1, 2'd2, 5'd2, 32'h101, 32'h0, 0, 0, 5'd1);
    for (int i = 0; i < 20; i++)
      step("R10", 1, 2'(i % 4), 5'(i % 6), 32'(i + 512), 32'(i * 3), 1, 0, 5'(i % 6));
    // mixed random traffic
    for (int i = 0; i < 600; i++)
      step("R2", ($urandom % 3) != 0, 2'($urandom % 4), 5'($urandom % 4),
           $urandom, $urandom, ($urandom % 3) == 0, ($urandom % 25) == 0, 5'($urandom % 4));
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule